// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor reach a small map of 28 byte-wide registers over a four-wire serial link. The host drives the serial clock, a data line into the block, and a frame line that stays high for the whole transfer. The block drives one data line back. All four serial signals are brought into the system clock domain through synchronizers, and all decisions are made there. The serial clock must run at no more than one quarter of the system clock.

A transfer is 16 serial clock periods long, sent most significant bit first and sampled on rising serial clock edges. The first byte is a command: bit 7 set means read and clear means write, bit 6 is ignored, and bits 5:0 carry the register address. The second byte is either write data from the host or read data from the block. Twelve configuration bytes are stored inside the block and appear on a flat output bus. The other readable locations return external status inputs, a transfer status byte, or two fixed identity bytes. The block checks each write against the address and the value, records the outcome as a status code, and drops a half-sent transfer when the frame is released or the serial clock stops for too long.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset the configuration bytes at addresses 0x00, 0x01, 0x02, 0x03 hold 0x78, 0x56, 0x34, 0x12, those at 0x10 to 0x17 hold 0x00, the status code is 0, and `miso` is low.
- R2: A 16-bit transfer with command bit 7 clear writes the second byte into a writable address (0x00 to 0x03, 0x10 to 0x17) and sets status 0. Command bit 6 has no effect. Configuration byte k of `cfg_o` (bits 8k+7:8k) is address k for k < 4 and address 0x10+(k-4) for k >= 4.
- R3: With command bit 7 set, the addressed byte is captured after the 8th rising serial clock edge. Its bit 7 appears on `miso` before the 9th rising edge, and each later rising edge moves `miso` to the next lower bit.
- R4: Reads of 0x04 to 0x0F return byte (address-4) of `stat_i`. 0x1B returns `hw_id_i`. 0x19 returns 0x03 and 0x1A returns 0x18.
- R5: A write to an existing address other than 0x00 to 0x03 and 0x10 to 0x17 changes no register and sets status 4.
- R6: A command whose address is above 0x1B sets status 3 once its 8th bit arrives. Such a read returns 0x00, and such a write changes nothing.
- R7: Bits 3:0 of address 0x12 form a mode field with legal codes 0 to 7. A write whose low nibble is 8 to 15 is rejected in full, so the register keeps its old value, and the write sets status 4.
- R8: A 17th rising serial clock edge in one frame sets status 2 (overflow). A write completed at the 16th edge remains in place.
- R9: The status code is read at address 0x18 as {5'b0, code}. The value returned is the code from before the current transfer, and a correct read sets it back to 0.
- R10: If the frame is held high with a partial transfer and no rising serial clock edge arrives for `TIMEOUT_CYC` system clocks, the partial bits are dropped and the next bit starts a new command.
- R11: When the frame is released, the bit count clears, a partial transfer is dropped without a register or status change, and `miso` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| frame | input | 1 | Frame line, high for the duration of a transfer |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, always driven |
| stat_i | input | 96 | Status bytes for addresses 0x04 to 0x0F, byte 0 at the low end |
| hw_id_i | input | 8 | Value returned at address 0x1B |
| cfg_o | output | 96 | Twelve stored configuration bytes |

## Verification
A wrong bit count is the most likely fault inside this block. It shifts which edge captures the command and which edge commits the write, so it shows up in the first read transfer as a byte rotated by one position on `miso`, or as the wrong value on `cfg_o` within a few system clocks of the 16th edge. A wrong status state stays hidden until the host reads address 0x18, so each error case is followed at once by a status read. This also checks that the value returned is the code from before the read. A timer that has stopped or never fires only shows when a later frame is judged: the write lands on the wrong register or is flagged as overflow.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BITS  = 2 * BYTE_W;
  localparam int unsigned REG_COUNT   = 28;
  localparam int unsigned CFG_COUNT   = 12;
  localparam int unsigned STAT_COUNT  = 12;
  localparam int unsigned ADDR_W      = 6;

  localparam logic [ADDR_W-1:0] ADDR_STAT_LO = 6'h04;
  localparam logic [ADDR_W-1:0] ADDR_STAT_HI = 6'h0F;
  localparam logic [ADDR_W-1:0] ADDR_XSTAT   = 6'h18;
  localparam logic [ADDR_W-1:0] ADDR_ID_A    = 6'h19;
  localparam logic [ADDR_W-1:0] ADDR_ID_B    = 6'h1A;
  localparam logic [ADDR_W-1:0] ADDR_HWID    = 6'h1B;
  localparam logic [ADDR_W-1:0] ADDR_MODE    = 6'h12;

  localparam logic [BYTE_W-1:0] ID_A_VAL = 8'h03;
  localparam logic [BYTE_W-1:0] ID_B_VAL = 8'h18;
  localparam logic [3:0]        MODE_MAX = 4'd7;

  typedef enum logic [2:0] {
    XS_OK       = 3'd0,
    XS_OVERFLOW = 3'd2,
    XS_BAD_ADDR = 3'd3,
    XS_BAD_WR   = 3'd4
  } xfer_status_e;

  // Writable window: low bank 0x00..0x03 and high bank 0x10..0x17
  function automatic logic cfg_hit(input logic [ADDR_W-1:0] a);
    return (a <= 6'h03) || ((a >= 6'h10) && (a <= 6'h17));
  endfunction

  function automatic logic [3:0] cfg_index(input logic [ADDR_W-1:0] a);
    return (a <= 6'h03) ? a[3:0] : 4'(a - 6'd12);
  endfunction

  function automatic logic [BYTE_W-1:0] cfg_reset(input int unsigned k);
    return (k < 4) ? 8'(8'h78 - 8'(k) * 8'h22) : 8'h00;
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= async_i;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              frame_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] shift_next,
  output logic              cmd_stb,
  output logic              data_stb,
  output logic              ovf_stb,
  output logic              miso
);
  localparam int unsigned CW = $clog2(FRAME_BITS + 2);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_CMD  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] CNT_DATA = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CNT_OVF  = CW'(FRAME_BITS);
  localparam logic [TW-1:0] T_LAST   = TW'(TIMEOUT_CYC - 1);

  logic              sclk_q;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [TW-1:0]     timer;
  logic              rise;
  logic              expire;

  assign rise       = frame_s && sclk_s && !sclk_q;
  assign expire     = frame_s && (cnt != '0) && (timer == T_LAST);
  assign shift_next = {sh[BYTE_W-2:0], mosi_s};
  assign cmd_stb    = rise && (cnt == CNT_CMD);
  assign data_stb   = rise && (cnt == CNT_DATA);
  assign ovf_stb    = rise && (cnt == CNT_OVF);
  assign miso       = tx[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      timer  <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!frame_s) begin
        cnt   <= '0;
        sh    <= '0;
        tx    <= '0;
        timer <= '0;
      end else if (rise) begin
        timer <= '0;
        sh    <= shift_next;
        if (cnt <= CNT_OVF) cnt <= cnt + 1'b1;
        tx <= (cnt == CNT_CMD) ? rd_data : {tx[BYTE_W-2:0], 1'b0};
      end else if (expire) begin
        cnt   <= '0;
        tx    <= '0;
        timer <= '0;
      end else if (cnt != '0) begin
        timer <= timer + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_stb,
  input  logic                         data_stb,
  input  logic                         ovf_stb,
  input  logic [BYTE_W-1:0]            shift_next,
  input  logic [STAT_COUNT*BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0]            hw_id_i,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [CFG_COUNT*BYTE_W-1:0]  cfg_o,
  output logic [2:0]                   status_o
);
  logic [BYTE_W-1:0] cfg_q [CFG_COUNT];
  xfer_status_e      status_q;
  logic              rd_flag_q;
  logic              addr_bad_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ra;
  logic [3:0]        soff;
  logic              mode_ok;

  genvar k;
  generate
    for (k = 0; k < CFG_COUNT; k++) begin : g_pack
      assign cfg_o[k*BYTE_W +: BYTE_W] = cfg_q[k];
    end
  endgenerate

  assign ra       = shift_next[ADDR_W-1:0];
  assign soff     = 4'(ra - ADDR_STAT_LO);
  assign status_o = status_q;
  assign mode_ok  = !((addr_q == ADDR_MODE) && (shift_next[3:0] > MODE_MAX));

  always_comb begin
    rd_data = '0;
    if (cfg_hit(ra))                                 rd_data = cfg_q[cfg_index(ra)];
    else if (ra >= ADDR_STAT_LO && ra <= ADDR_STAT_HI) rd_data = stat_i[{soff, 3'b000} +: BYTE_W];
    else if (ra == ADDR_XSTAT)                       rd_data = {5'b0, status_q};
    else if (ra == ADDR_ID_A)                        rd_data = ID_A_VAL;
    else if (ra == ADDR_ID_B)                        rd_data = ID_B_VAL;
    else if (ra == ADDR_HWID)                        rd_data = hw_id_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_COUNT; i++) cfg_q[i] <= cfg_reset(i);
      status_q   <= XS_OK;
      rd_flag_q  <= 1'b0;
      addr_bad_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      if (cmd_stb) begin
        rd_flag_q  <= shift_next[BYTE_W-1];
        addr_q     <= ra;
        addr_bad_q <= (ra >= ADDR_W'(REG_COUNT));
        if (ra >= ADDR_W'(REG_COUNT)) status_q <= XS_BAD_ADDR;
      end
      if (data_stb && !addr_bad_q) begin
        if (rd_flag_q) begin
          status_q <= XS_OK;
        end else if (!cfg_hit(addr_q) || !mode_ok) begin
          status_q <= XS_BAD_WR;
        end else begin
          cfg_q[cfg_index(addr_q)] <= shift_next;
          status_q <= XS_OK;
        end
      end
      if (ovf_stb) status_q <= XS_OVERFLOW;
    end
  end
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         frame,
  input  logic                         mosi,
  output logic                         miso,
  input  logic [STAT_COUNT*BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0]            hw_id_i,
  output logic [CFG_COUNT*BYTE_W-1:0]  cfg_o
);
  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              frame_s;
  logic              mosi_s;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] shift_next;
  logic              cmd_stb;
  logic              data_stb;
  logic              ovf_stb;
  logic [2:0]        status_w;

  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sclk, frame, mosi}),
    .sync_o(pins_s)
  );
  assign {sclk_s, frame_s, mosi_s} = pins_s;

  spi_rf_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .frame_s(frame_s), .mosi_s(mosi_s),
    .rd_data(rd_data), .shift_next(shift_next),
    .cmd_stb(cmd_stb), .data_stb(data_stb), .ovf_stb(ovf_stb),
    .miso(miso)
  );

  spi_rf_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_stb(cmd_stb), .data_stb(data_stb), .ovf_stb(ovf_stb),
    .shift_next(shift_next), .stat_i(stat_i), .hw_id_i(hw_id_i),
    .rd_data(rd_data), .cfg_o(cfg_o), .status_o(status_w)
  );
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk
  import spi_rf_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        frame_s,
  input logic                        miso,
  input logic                        cmd_stb,
  input logic                        data_stb,
  input logic                        ovf_stb,
  input logic [2:0]                  status_w,
  input logic [CFG_COUNT*BYTE_W-1:0] cfg_o
);
  localparam int unsigned MODE_LSB = BYTE_W * cfg_index(ADDR_MODE);

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_s |=> !miso); // R11

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w == 3'd0) || (status_w == 3'd2) || (status_w == 3'd3) || (status_w == 3'd4)); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_stb |=> $stable(cfg_o)); // R5

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[MODE_LSB +: 4] <= MODE_MAX); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, data_stb, ovf_stb})); // R3

  AST_OVF_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |=> (status_w == 3'd2)); // R8
endmodule

bind spi_regfile_slave spi_regfile_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_s(frame_s), .miso(miso),
  .cmd_stb(cmd_stb), .data_stb(data_stb), .ovf_stb(ovf_stb),
  .status_w(status_w), .cfg_o(cfg_o)
);

// File: tb/tb_spi_regfile_slave.sv
module tb_spi_regfile_slave;
  localparam int unsigned TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        frame = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic [95:0] stat_i;
  logic [7:0]  hw_id_i = 8'hC7;
  logic [95:0] cfg_o;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spi_regfile_slave #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame(frame), .mosi(mosi),
    .miso(miso), .stat_i(stat_i), .hw_id_i(hw_id_i), .cfg_o(cfg_o)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", t, a, e);
      end
    end
  end

  task automatic expect_byte(input string tag, input logic [7:0] e, input logic [7:0] a);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  task automatic frame_open();
    @(negedge clk); frame = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_close();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    frame = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // bits left-aligned in a 24-bit word, bit i sent = bits[23-i]
  task automatic send_bits(input logic [23:0] bits, input int n, output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      mosi = bits[23-i];
      repeat (4) @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rd);
    frame_open();
    send_bits({cmd, dat, 8'h00}, 16, rd);
    frame_close();
  endtask

  function automatic logic [7:0] cfg_byte(input int k);
    return cfg_o[k*8 +: 8];
  endfunction

  initial begin
    logic [7:0] rd;
    for (int k = 0; k < 12; k++) stat_i[k*8 +: 8] = 8'(8'h40 + k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 12; k++)
      expect_byte("R1 cfg reset", (k < 4) ? 8'(8'h78 - 8'h22 * k) : 8'h00, cfg_byte(k));
    expect_byte("R1 miso idle", 8'h00, {7'b0, miso});
    xfer(8'h98, 8'h00, rd);
    expect_byte("R1 R9 status after reset", 8'h00, rd);

    // R2 writes, bit 6 ignored
    xfer(8'h10, 8'hA5, rd);
    expect_byte("R2 write 0x10", 8'hA5, cfg_byte(4));
    xfer(8'h51, 8'h3C, rd);
    expect_byte("R2 bit6 ignored write 0x11", 8'h3C, cfg_byte(5));
    xfer(8'h02, 8'hE1, rd);
    expect_byte("R2 write 0x02", 8'hE1, cfg_byte(2));

    // R3 read back
    xfer(8'h90, 8'h00, rd);
    expect_byte("R3 read 0x10", 8'hA5, rd);
    xfer(8'hD1, 8'h00, rd);
    expect_byte("R3 read 0x11 bit6 set", 8'h3C, rd);

    // R4 read-only sources
    xfer(8'h85, 8'h00, rd);
    expect_byte("R4 status input 0x05", 8'h41, rd);
    xfer(8'h8F, 8'h00, rd);
    expect_byte("R4 status input 0x0F", 8'h4B, rd);
    xfer(8'h9B, 8'h00, rd);
    expect_byte("R4 hw id 0x1B", 8'hC7, rd);
    xfer(8'h99, 8'h00, rd);
    expect_byte("R4 id 0x19", 8'h03, rd);
    xfer(8'h9A, 8'h00, rd);
    expect_byte("R4 id 0x1A", 8'h18, rd);

    // R5 write to read-only address
    xfer(8'h06, 8'h99, rd);
    xfer(8'h98, 8'h00, rd);
    expect_byte("R5 status after ro write", 8'h04, rd);
    xfer(8'h86, 8'h00, rd);
    expect_byte("R5 ro value unchanged", 8'h42, rd);
    xfer(8'h19, 8'h55, rd);
    xfer(8'h99, 8'h00, rd);
    expect_byte("R5 id unchanged", 8'h03, rd);

    // R6 address out of range
    xfer(8'hA0, 8'h00, rd);
    expect_byte("R6 read bad addr data", 8'h00, rd);
    xfer(8'h98, 8'h00, rd);
    expect_byte("R6 status bad addr read", 8'h03, rd);
    xfer(8'h3F, 8'h11, rd);
    xfer(8'h98, 8'h00, rd);
    expect_byte("R6 status bad addr write", 8'h03, rd);
    expect_byte("R6 cfg untouched", 8'hA5, cfg_byte(4));

    // R9 status cleared by a good read
    xfer(8'h98, 8'h00, rd);
    expect_byte("R9 status back to ok", 8'h00, rd);

    // R7 mode field
    xfer(8'h12, 8'h65, rd);
    expect_byte("R7 legal mode write", 8'h65, cfg_byte(6));
    xfer(8'h12, 8'h0B, rd);
    expect_byte("R7 illegal mode kept old", 8'h65, cfg_byte(6));
    xfer(8'h98, 8'h00, rd);
    expect_byte("R7 status illegal mode", 8'h04, rd);
    xfer(8'h12, 8'h07, rd);
    expect_byte("R7 mode 7 accepted", 8'h07, cfg_byte(6));

    // R8 overflow
    frame_open();
    send_bits({8'h13, 8'h77, 8'hFF}, 24, rd);
    frame_close();
    expect_byte("R8 write before overflow kept", 8'h77, cfg_byte(7));
    xfer(8'h98, 8'h00, rd);
    expect_byte("R8 status overflow", 8'h02, rd);

    // R10 idle timeout mid-frame
    frame_open();
    send_bits(24'hFFFFFF, 5, rd);
    sclk = 1'b0;
    repeat (TMO + 40) @(negedge clk);
    send_bits({8'h17, 8'h9C, 8'h00}, 16, rd);
    frame_close();
    expect_byte("R10 fresh command after timeout", 8'h9C, cfg_byte(11));
    xfer(8'h98, 8'h00, rd);
    expect_byte("R10 status after timeout", 8'h00, rd);

    // R11 frame released mid-transfer
    xfer(8'h06, 8'h00, rd);  // status 4 marker
    frame_open();
    send_bits({8'h16, 8'hEE, 8'h00}, 12, rd);
    frame_close();
    expect_byte("R11 partial write dropped", 8'h00, cfg_byte(10));
    expect_byte("R11 miso low after release", 8'h00, {7'b0, miso});
    xfer(8'h98, 8'h00, rd);
    expect_byte("R11 status unchanged", 8'h04, rd);
    xfer(8'h16, 8'h44, rd);
    expect_byte("R11 next frame starts fresh", 8'h44, cfg_byte(10));

    repeat (4) @(negedge clk);
    while (act_q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule